// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses for one burst of a double-data-rate SDRAM-style memory. A start strobe captures a start column, a 3-bit burst length code and a burst type bit. The block then emits one column address per clock, with a valid flag and a flag that marks the final beat. Read and write bursts both use the same sequencer, and they use the same length and type settings.

A burst stays inside an aligned block of columns. The size of that block equals the burst length, so the column bits above the block never change during a burst. The low bits start at the given column and wrap at the block edge. They advance either linearly or in the exclusive-or (interleaved) order. Only the lengths 2, 4 and 8 can start a burst. A strobe that carries any other code is dropped.

Control is a two-state machine:
- In `IDLE`, a strobe with a legal code takes the transition *accept*, which goes to `RUN`. A strobe with an illegal code takes *reject* and stays in `IDLE`.
- In `RUN`, the transition *step* stays in `RUN` for every beat except the last. The transition *finish* returns to `IDLE` on the last beat.
- Strobes seen in `RUN` have no effect.

Top module: `burst_col_seq`

## Requirements
- R1: The length code (`len_code_i`) sets the number of beats: 3'b001 gives 2 beats, 3'b010 gives 4 beats and 3'b011 gives 8 beats.
- R2: Any other length code (3'b000 or 3'b100 to 3'b111) starts no burst, and `valid_o` stays low.
- R3: With `interleave_i`=0 (sequential), the low log2(L) bits of beat k equal (start + k) mod L, where L is the burst length.
- R4: With `interleave_i`=1 (interleaved), the low log2(L) bits of beat k equal start XOR k.
- R5: Beat 0 appears one clock after the accepted strobe, and it equals `start_col_i` exactly.
- R6: Column bits above the block (bit 1 and up for L=2, bit 2 and up for L=4, bit 3 and up for L=8) keep their start values for every beat of the burst.
- R7: `last_o` is high only on beat L-1. `valid_o` falls on the clock after the last beat.
- R8: A strobe that arrives while a burst is running is ignored. Changes to the address, length or type inputs during a burst also have no effect, and the running sequence continues unchanged.
- R9: During and after reset, `valid_o` and `last_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, sampled in IDLE |
| start_col_i | input | COL_W | Start column address |
| len_code_i | input | 3 | Burst length code |
| interleave_i | input | 1 | Burst type: 0 sequential, 1 interleaved |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | Final beat of the burst |

## Verification
A corrupted beat counter shows up in `col_o` on the very next beat. It also shifts `last_o` or the fall of `valid_o` away from beat L-1, so the whole burst has the wrong length. A corrupted captured mask or base changes either the wrap point or the upper column bits, and the comparison with the reference sequence catches this on the first beat where the two differ. A state register that is stuck in `RUN` or in `IDLE` shows within one clock of a strobe, as `valid_o` that never falls or never rises.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
    localparam int OFS_W = 3;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } bcs_state_e;

    localparam logic [2:0] CODE_L2 = 3'b001;
    localparam logic [2:0] CODE_L4 = 3'b010;
    localparam logic [2:0] CODE_L8 = 3'b011;
endpackage

// File: rtl/bcs_len_decode.sv
module bcs_len_decode
    import bcs_pkg::*;
(
    input  logic [2:0]       code_i,
    output logic             legal_o,
    output logic [OFS_W-1:0] mask_o
);
    always_comb begin
        legal_o = 1'b1;
        mask_o  = '0;
        case (code_i)
            CODE_L2: mask_o = 3'b001;
            CODE_L4: mask_o = 3'b011;
            CODE_L8: mask_o = 3'b111;
            default: legal_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/bcs_beat_order.sv
module bcs_beat_order
    import bcs_pkg::*;
(
    input  logic [OFS_W-1:0] first_i,
    input  logic [OFS_W-1:0] beat_i,
    input  logic [OFS_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [OFS_W-1:0] low_o
);
    logic [OFS_W-1:0] lin_sum;
    logic [OFS_W-1:0] xor_sum;

    always_comb begin
        lin_sum = first_i + beat_i;
        xor_sum = first_i ^ beat_i;
        low_o   = (ilv_i ? xor_sum : lin_sum) & mask_i;
    end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       len_code_i,
    input  logic             interleave_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o
);
    localparam int HI_W = COL_W - OFS_W;

    generate
        if (COL_W < OFS_W) begin : g_bad_width
            $error("COL_W must be at least 3");
        end
    endgenerate

    bcs_state_e       state_q, state_d;
    logic [COL_W-1:0] base_q;
    logic [OFS_W-1:0] mask_q;
    logic [OFS_W-1:0] beat_q;
    logic             ilv_q;

    logic             code_legal;
    logic [OFS_W-1:0] code_mask;
    logic [OFS_W-1:0] low_bits;
    logic             accept;
    logic             at_last;

    bcs_len_decode u_dec (
        .code_i  (len_code_i),
        .legal_o (code_legal),
        .mask_o  (code_mask)
    );

    bcs_beat_order u_ord (
        .first_i (base_q[OFS_W-1:0]),
        .beat_i  (beat_q),
        .mask_i  (mask_q),
        .ilv_i   (ilv_q),
        .low_o   (low_bits)
    );

    assign accept  = (state_q == ST_IDLE) && start_i && code_legal;
    assign at_last = (state_q == ST_RUN) && (beat_q == mask_q);

    // next state: accept / reject in IDLE, step / finish in RUN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)  state_d = ST_RUN;
            ST_RUN:  if (at_last) state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // burst context captured on accept, beat counter advanced on step
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            mask_q <= '0;
            ilv_q  <= 1'b0;
            beat_q <= '0;
        end else if (accept) begin
            base_q <= start_col_i;
            mask_q <= code_mask;
            ilv_q  <= interleave_i;
            beat_q <= '0;
        end else if ((state_q == ST_RUN) && !at_last) begin
            beat_q <= beat_q + OFS_W'(1);
        end
    end

    // outputs
    always_comb begin
        valid_o = 1'b0;
        last_o  = 1'b0;
        col_o   = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN: begin
                valid_o = 1'b1;
                last_o  = at_last;
                col_o   = (base_q & ~{{HI_W{1'b0}}, mask_q})
                        | {{HI_W{1'b0}}, low_bits};
            end
        endcase
    end
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic [2:0]       len_code_i,
    input logic             valid_o,
    input logic             last_o,
    input logic [COL_W-1:0] col_o
);
    logic       legal;
    logic [3:0] cnt;

    assign legal = (len_code_i == 3'b001) || (len_code_i == 3'b010) || (len_code_i == 3'b011);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (valid_o) cnt <= cnt + 4'd1;
        else              cnt <= '0;
    end

    AST_RESERVED_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && start_i && !legal) |=> !valid_o); // R2

    AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && start_i && legal) |=> (valid_o && col_o == $past(start_col_i))); // R5

    AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |=> $stable(col_o[COL_W-1:3])); // R6

    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> !valid_o); // R7

    AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o); // R7

    AST_NO_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |=> valid_o); // R8

    AST_MAX_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && cnt == 4'd7) |-> last_o); // R1

    always_comb begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!valid_o && !last_o); // R9
        end
    end
endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W)) u_chk (.*);

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int COL_W      = 10;
    localparam int NVEC       = 8;

    // {start column, length code, type}
    localparam logic [COL_W+3:0] VEC [NVEC] = '{
        {10'h2A5, 3'b001, 1'b0},
        {10'h13E, 3'b010, 1'b0},
        {10'h3FF, 3'b011, 1'b0},
        {10'h0C6, 3'b011, 1'b1},
        {10'h155, 3'b010, 1'b1},
        {10'h201, 3'b000, 1'b0},
        {10'h377, 3'b100, 1'b1},
        {10'h0F3, 3'b111, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [2:0]       len_code_i = '0;
    logic             interleave_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             valid_o;
    logic             last_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .len_code_i(len_code_i), .interleave_i(interleave_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int beats_of(input logic [2:0] code);
        case (code)
            3'b001:  return 2;
            3'b010:  return 4;
            3'b011:  return 8;
            default: return 0;
        endcase
    endfunction

    function automatic logic [COL_W-1:0] ref_col(input logic [COL_W-1:0] s,
                                                input int len, input bit ilv, input int k);
        int m;
        int lo;
        m  = len - 1;
        lo = ilv ? ((s & m) ^ k) : (((s & m) + k) % len);
        return (s & ~COL_W'(m)) | COL_W'(lo);
    endfunction

    // strobe for one cycle, then check each beat at the falling edge
    task automatic run_burst(input logic [COL_W-1:0] s, input logic [2:0] code,
                             input bit ilv, input bit disturb);
        int len;
        string req;
        len = beats_of(code);
        req = ilv ? "R4" : "R3";
        @(negedge clk);
        start_i = 1'b1; start_col_i = s; len_code_i = code; interleave_i = ilv;
        @(negedge clk);
        start_i = 1'b0;
        if (len == 0) begin
            check("R2 no burst on reserved code", int'(valid_o), 0);
            return;
        end
        for (int k = 0; k < len; k++) begin
            if (disturb && k == 1) begin
                start_i = 1'b1; start_col_i = ~s; len_code_i = 3'b001; interleave_i = ~ilv;
            end
            if (disturb && k == 3) start_i = 1'b0;
            check("R1 valid during burst", int'(valid_o), 1);
            check(disturb ? "R8 sequence kept" : req, int'(col_o), int'(ref_col(s, len, ilv, k)));
            check("R6 upper bits held", int'(col_o >> $clog2(len)), int'(s >> $clog2(len)));
            check("R7 last flag", int'(last_o), (k == len - 1) ? 1 : 0);
            if (k == 0) check("R5 first beat", int'(col_o), int'(s));
            @(negedge clk);
        end
        start_i = 1'b0;
        check("R7 valid drops after last", int'(valid_o), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R9: outputs quiet in reset, even with a strobe present
        start_i = 1'b1; len_code_i = 3'b011;
        #(CLK_PERIOD * 3 + 1);
        check("R9 valid in reset", int'(valid_o), 0);
        check("R9 last in reset", int'(last_o), 0);
        start_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 valid after reset", int'(valid_o), 0);

        for (int i = 0; i < NVEC; i++)
            run_burst(VEC[i][COL_W+3:4], VEC[i][3:1], VEC[i][0], 1'b0);

        // every start offset, length and type
        for (int t = 0; t < 2; t++)
            for (int c = 1; c <= 3; c++)
                for (int s = 0; s < 8; s++)
                    run_burst(COL_W'(10'h1C0 + s), 3'(c), t[0], 1'b0);

        // R2: all reserved codes
        run_burst(10'h050, 3'b101, 1'b0, 1'b0);
        run_burst(10'h050, 3'b110, 1'b1, 1'b0);

        // R8: strobe and input changes mid-burst
        run_burst(10'h2ED, 3'b011, 1'b0, 1'b1);
        run_burst(10'h0A3, 3'b011, 1'b1, 1'b1);
        run_burst(10'h3F2, 3'b010, 1'b0, 1'b1);

        // R1: upper boundary of the column space wraps within block
        run_burst(10'h3FE, 3'b010, 1'b0, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule